// File: doc/BRIEF.md
# Circular Video Frame Buffer Slot Manager

This block manages a ring of whole-frame buffers held in external memory between one video producer and one video consumer. It moves no pixels. It keeps one status per frame slot and hands each side the start address of the slot it may use next. It holds back whichever side has nothing to work on. Each slot is free, being filled, holding a finished frame, or being drained. The producer claims a free slot, fills it through its own memory path and then reports the frame as finished. The consumer claims finished slots in the same circular order and releases each one when its read is over.

Slot addresses come from parameters. One slot spans the pixels per frame times the bytes per pixel. Slot k starts at the region base plus k times that span, and the whole region spans the slot count times one slot. An optional frame-sync input lets the consumer start a new frame only in a cycle where downstream video timing marks a frame boundary. A running count of finished, unclaimed frames is also provided.

Top module: `vfb_ring_mgr`

## Requirements
- R1: After reset all slots are free, both write and read pointers are at slot 0, `ready_cnt` is 0, no grant is pulsed, `wr_blocked` is 0 and `rd_blocked` is 1.
- R2: A `wr_start` pulse in a cycle where the writer holds no slot and the slot at the write pointer is free claims that slot. In the next cycle `wr_grant` is 1 for one cycle and `wr_base` equals BASE_ADDR + slot × PIX_PER_FRAME × BYTES_PER_PIX.
- R3: When the writer holds no slot and the slot at the write pointer is not free, `wr_blocked` is 1, and a `wr_start` in that cycle gives no grant and changes no state.
- R4: A slot becomes claimable by the reader only after `wr_done` for it. While the writer holds no finished frame at the read pointer and the reader holds nothing, `rd_blocked` is 1 and `rd_req` gives no grant.
- R5: The write and read pointers each step through slots 0, 1, …, NUM_SLOTS−1 and then wrap to 0. A pointer advances on the done of the frame it holds.
- R6: A reader claim (`rd_grant` with `rd_base` of the slot, same formula as R2) is only given for a finished slot. `rd_done` returns that slot to free. The reader never holds the slot the writer holds.
- R7: `ready_cnt` equals the number of finished frames not yet claimed by the reader. It rises on an accepted `wr_done` and falls on a reader grant, and ranges from 0 to NUM_SLOTS.
- R8: With USE_FSYNC = 1, a reader claim happens only in a cycle where `rd_fsync` is 1. With USE_FSYNC = 0, `rd_fsync` has no effect.
- R9: `wr_done` or `rd_done` while that side holds no slot, and `wr_start` or `rd_req` while that side already holds one, are ignored.
- R10: NUM_SLOTS outside 3 to 64 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Producer asks for a slot to fill |
| wr_done | input | 1 | Producer has finished the slot it holds |
| wr_grant | output | 1 | One-cycle pulse: a slot was given to the producer |
| wr_base | output | ADDR_W | Start address of the producer's slot |
| wr_blocked | output | 1 | Producer idle and next slot not free |
| rd_req | input | 1 | Consumer asks for a finished frame |
| rd_fsync | input | 1 | Downstream frame boundary marker |
| rd_done | input | 1 | Consumer has finished the slot it holds |
| rd_grant | output | 1 | One-cycle pulse: a slot was given to the consumer |
| rd_base | output | ADDR_W | Start address of the consumer's slot |
| rd_blocked | output | 1 | Consumer idle and next slot not finished |
| ready_cnt | output | $clog2(NUM_SLOTS+1) | Finished frames waiting for the consumer |

## Verification
The bench fills the ring to the brim and then tries one more start. A design that tests fullness by pointer equality alone would grant a fifth slot and overwrite an unread frame. It drains across the wrap from the last slot back to slot 0, where an off-by-one wrap would hand out an address past the region. A long pseudo-random run applies starts, dones and requests together, including same-cycle finish-and-claim and dones with no held slot. That run catches a counter that double-counts simultaneous events or a stray done that frees a slot. A separate instance with frame sync enabled shows that a request without the sync marker is held off and the marked cycle is granted.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
   localparam int MIN_SLOTS = 3;
   localparam int MAX_SLOTS = 64;
   localparam int SLOT_W    = $clog2(MAX_SLOTS);

   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_READY = 2'd2,
      SLOT_DRAIN = 2'd3
   } slot_st_e;
endpackage

// File: rtl/vfb_slot_cell.sv
module vfb_slot_cell
   import vfb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     claim_wr,
   input  logic     commit_wr,
   input  logic     claim_rd,
   input  logic     release_rd,
   output slot_st_e st
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SLOT_FREE;
      end else begin
         unique case (st)
            SLOT_FREE:  if (claim_wr)   st <= SLOT_FILL;
            SLOT_FILL:  if (commit_wr)  st <= SLOT_READY;
            SLOT_READY: if (claim_rd)   st <= SLOT_DRAIN;
            SLOT_DRAIN: if (release_rd) st <= SLOT_FREE;
            default:                    st <= SLOT_FREE;
         endcase
      end
   end

   // R3: the writer only ever claims a free slot
   assert_wr_claims_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      claim_wr |-> st == SLOT_FREE);
   // R4: the reader never claims a slot still being filled
   assert_rd_not_filling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st == SLOT_FILL |-> !claim_rd);
   // R6: a drained slot goes straight back to free
   assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SLOT_DRAIN && release_rd) |=> st == SLOT_FREE);
endmodule

// File: rtl/vfb_ring_ptr.sv
module vfb_ring_ptr #(
   parameter int NUM_SLOTS = 4,
   parameter int PTR_W     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)          ptr <= '0;
      else if (adv)        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr == LAST) |=> ptr == '0);
   assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
endmodule

// File: rtl/vfb_occ_count.sv
module vfb_occ_count #(
   parameter int NUM_SLOTS = 4,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(NUM_SLOTS));
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == '0 |-> !dec);
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == CNT_W'(NUM_SLOTS) |-> !inc);
endmodule

// File: rtl/vfb_ring_mgr.sv
module vfb_ring_mgr
   import vfb_pkg::*;
#(
   parameter int                NUM_SLOTS     = 4,
   parameter int                PIX_PER_FRAME = 1920 * 1080,
   parameter int                BYTES_PER_PIX = 4,
   parameter int                ADDR_W        = 32,
   parameter longint unsigned   BASE_ADDR     = 64'h8000_0000,
   parameter bit                USE_FSYNC     = 1'b1,
   localparam int               CNT_W         = $clog2(NUM_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_done,
   output logic              wr_grant,
   output logic [ADDR_W-1:0] wr_base,
   output logic              wr_blocked,
   input  logic              rd_req,
   input  logic              rd_fsync,
   input  logic              rd_done,
   output logic              rd_grant,
   output logic [ADDR_W-1:0] rd_base,
   output logic              rd_blocked,
   output logic [CNT_W-1:0]  ready_cnt
);
   localparam longint unsigned FRAME_BYTES  = longint'(PIX_PER_FRAME) * BYTES_PER_PIX;
   localparam longint unsigned REGION_BYTES = longint'(NUM_SLOTS) * FRAME_BYTES;

   // R10: elaboration-time legality checks
   if (NUM_SLOTS < MIN_SLOTS || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("vfb_ring_mgr: NUM_SLOTS must lie in 3..64");
   end
   if (ADDR_W < 8 || ADDR_W > 62) begin : g_bad_addr_w
      $error("vfb_ring_mgr: ADDR_W must lie in 8..62");
   end
   if (PIX_PER_FRAME < 1 || BYTES_PER_PIX < 1) begin : g_bad_frame
      $error("vfb_ring_mgr: frame geometry must be positive");
   end
   if (BASE_ADDR + REGION_BYTES > (64'd1 << ADDR_W)) begin : g_bad_region
      $error("vfb_ring_mgr: frame region exceeds the address space");
   end

   logic [SLOT_W-1:0] wp, rp;
   slot_st_e          slot_st [NUM_SLOTS];
   slot_st_e          cur_w, cur_r;
   logic              wr_act, rd_act;
   logic              wr_accept, wr_commit, rd_accept, rd_release, rd_gate;

   // state of the slot under each pointer
   always_comb begin
      cur_w = SLOT_FREE;
      cur_r = SLOT_FREE;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (wp == SLOT_W'(i)) cur_w = slot_st[i];
         if (rp == SLOT_W'(i)) cur_r = slot_st[i];
      end
   end

   // frame-sync gating variant
   if (USE_FSYNC) begin : g_fsync
      assign rd_gate = rd_fsync;
      // R8: every reader claim lines up with a sync marker
      assert_claim_on_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
         rd_grant |-> $past(rd_fsync));
   end else begin : g_free_run
      logic fsync_unused;
      assign fsync_unused = rd_fsync;
      assign rd_gate      = 1'b1 | fsync_unused;
   end

   assign wr_accept  = wr_start && !wr_act && (cur_w == SLOT_FREE);
   assign wr_commit  = wr_done  &&  wr_act;
   assign rd_accept  = rd_req   && !rd_act && (cur_r == SLOT_READY) && rd_gate;
   assign rd_release = rd_done  &&  rd_act;

   assign wr_blocked = !wr_act && (cur_w != SLOT_FREE);
   assign rd_blocked = !rd_act && (cur_r != SLOT_READY);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      vfb_slot_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .claim_wr   (wr_accept  && wp == SLOT_W'(i)),
         .commit_wr  (wr_commit  && wp == SLOT_W'(i)),
         .claim_rd   (rd_accept  && rp == SLOT_W'(i)),
         .release_rd (rd_release && rp == SLOT_W'(i)),
         .st         (slot_st[i])
      );
   end

   vfb_ring_ptr #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(SLOT_W)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_commit), .ptr(wp));
   vfb_ring_ptr #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(SLOT_W)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(rd_release), .ptr(rp));

   vfb_occ_count #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .inc(wr_commit), .dec(rd_accept), .cnt(ready_cnt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_act   <= 1'b0;
         rd_act   <= 1'b0;
         wr_grant <= 1'b0;
         rd_grant <= 1'b0;
         wr_base  <= ADDR_W'(BASE_ADDR);
         rd_base  <= ADDR_W'(BASE_ADDR);
      end else begin
         wr_grant <= wr_accept;
         rd_grant <= rd_accept;
         if (wr_accept)      wr_act <= 1'b1;
         else if (wr_commit) wr_act <= 1'b0;
         if (rd_accept)       rd_act <= 1'b1;
         else if (rd_release) rd_act <= 1'b0;
         if (wr_accept) wr_base <= ADDR_W'(BASE_ADDR + longint'(wp) * FRAME_BYTES);
         if (rd_accept) rd_base <= ADDR_W'(BASE_ADDR + longint'(rp) * FRAME_BYTES);
      end
   end

   // R6: the two sides never hold the same slot
   assert_no_shared_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act && rd_act) |-> wp != rp);
   // R3: a blocked writer receives no grant
   assert_wr_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked |=> !wr_grant);
   // R4: a blocked reader receives no grant
   assert_rd_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_blocked |=> !rd_grant);
   // R9: a second start while holding a slot yields no grant
   assert_wr_single_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |=> !wr_grant);
endmodule

// File: tb/tb_vfb_ring_mgr.sv
`timescale 1ns/1ps
module tb_vfb_ring_mgr;
   localparam int              N     = 4;
   localparam int              PIX   = 4;
   localparam int              BPP   = 4;
   localparam int              FB    = PIX * BPP;
   localparam int              AW    = 32;
   localparam longint unsigned BASE  = 64'h1000;
   localparam int              CW    = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_start = 0, wr_done = 0, rd_req = 0, rd_fsync = 0, rd_done = 0;
   logic          wr_grant, wr_blocked, rd_grant, rd_blocked;
   logic [AW-1:0] wr_base, rd_base;
   logic [CW-1:0] ready_cnt;
   logic          f_wr_grant, f_wr_blocked, f_rd_grant, f_rd_blocked;
   logic [AW-1:0] f_wr_base, f_rd_base;
   logic [CW-1:0] f_ready_cnt;

   always #10 clk = ~clk;

   vfb_ring_mgr #(.NUM_SLOTS(N), .PIX_PER_FRAME(PIX), .BYTES_PER_PIX(BPP),
      .ADDR_W(AW), .BASE_ADDR(BASE), .USE_FSYNC(1'b0)) dut (
      .clk, .rst_n, .wr_start, .wr_done, .wr_grant, .wr_base, .wr_blocked,
      .rd_req, .rd_fsync, .rd_done, .rd_grant, .rd_base, .rd_blocked, .ready_cnt);

   vfb_ring_mgr #(.NUM_SLOTS(N), .PIX_PER_FRAME(PIX), .BYTES_PER_PIX(BPP),
      .ADDR_W(AW), .BASE_ADDR(BASE), .USE_FSYNC(1'b1)) dut_fs (
      .clk, .rst_n, .wr_start, .wr_done, .wr_grant(f_wr_grant), .wr_base(f_wr_base),
      .wr_blocked(f_wr_blocked), .rd_req, .rd_fsync, .rd_done, .rd_grant(f_rd_grant),
      .rd_base(f_rd_base), .rd_blocked(f_rd_blocked), .ready_cnt(f_ready_cnt));

   int n_cmp = 0, n_mis = 0;
   bit finished = 0;

   // reference model: 0 free, 1 filling, 2 finished, 3 draining
   int ms [N];
   int mwp, mrp, mcnt;
   bit mwa, mra;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_mis++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) ms[i] = 0;
      mwp = 0; mrp = 0; mcnt = 0; mwa = 0; mra = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      wr_start = 0; wr_done = 0; rd_req = 0; rd_fsync = 0; rd_done = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic check_levels(input string tag);
      chk(ready_cnt == CW'(mcnt), {tag, "/R7 ready_cnt"}, ready_cnt, mcnt);
      chk(wr_blocked == (!mwa && ms[mwp] != 0), {tag, "/R3 wr_blocked"},
          wr_blocked, (!mwa && ms[mwp] != 0));
      chk(rd_blocked == (!mra && ms[mrp] != 2), {tag, "/R4 rd_blocked"},
          rd_blocked, (!mra && ms[mrp] != 2));
   endtask

   // one cycle of stimulus, checked against the model after the edge
   task automatic step(input bit ws, input bit wd, input bit rq, input bit fs, input bit rdn);
      bit wacc, wcom, racc, rrel;
      int owp, orp;
      wacc = ws && !mwa && ms[mwp] == 0;
      wcom = wd && mwa;
      racc = rq && !mra && ms[mrp] == 2;
      rrel = rdn && mra;
      owp = mwp; orp = mrp;
      wr_start = ws; wr_done = wd; rd_req = rq; rd_fsync = fs; rd_done = rdn;
      @(negedge clk);
      wr_start = 0; wr_done = 0; rd_req = 0; rd_fsync = 0; rd_done = 0;
      if (wacc) begin ms[owp] = 1; mwa = 1; end
      if (wcom) begin ms[owp] = 2; mwa = 0; mwp = (owp + 1) % N; mcnt++; end
      if (racc) begin ms[orp] = 3; mra = 1; mcnt--; end
      if (rrel) begin ms[orp] = 0; mra = 0; mrp = (orp + 1) % N; end
      chk(wr_grant == wacc, "R2/R9 wr_grant", wr_grant, wacc);
      if (wacc)
         chk(wr_base == AW'(BASE + owp * FB), "R2/R5 wr_base", wr_base, BASE + owp * FB);
      chk(rd_grant == racc, "R6/R9 rd_grant", rd_grant, racc);
      if (racc)
         chk(rd_base == AW'(BASE + orp * FB), "R6/R5 rd_base", rd_base, BASE + orp * FB);
      check_levels("step");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_mis++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      do_reset();
      // R1: reset state
      chk(wr_grant == 0 && rd_grant == 0, "R1 grants", {wr_grant, rd_grant}, 0);
      chk(wr_blocked == 0, "R1 wr_blocked", wr_blocked, 0);
      chk(rd_blocked == 1, "R1 rd_blocked", rd_blocked, 1);
      chk(ready_cnt == 0, "R1 ready_cnt", ready_cnt, 0);

      // R4: a request before any finished frame is refused
      step(0, 0, 1, 1, 0);
      step(1, 0, 0, 0, 0);
      step(0, 0, 1, 1, 0);   // slot 0 still filling
      chk(rd_grant == 0, "R4 no read of filling slot", rd_grant, 0);
      // R9: duplicate start while holding is ignored
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      // R9: done with nothing held changes nothing
      step(0, 1, 0, 0, 0);
      chk(ready_cnt == 1, "R9 stray wr_done", ready_cnt, 1);
      step(0, 0, 0, 0, 1);
      chk(rd_blocked == 0, "R9 stray rd_done keeps frame", rd_blocked, 0);

      // R3/R5: fill the ring to the brim, then one more start
      for (int k = 1; k < N; k++) begin
         step(1, 0, 0, 0, 0);
         step(0, 1, 0, 0, 0);
      end
      chk(ready_cnt == CW'(N), "R7 full ring count", ready_cnt, N);
      chk(wr_blocked == 1, "R3 full ring blocks", wr_blocked, 1);
      step(1, 0, 0, 0, 0);
      chk(wr_grant == 0, "R3 start while full", wr_grant, 0);

      // R5/R6: drain one, writer wraps to slot 0
      step(0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      chk(wr_base == AW'(BASE), "R5 writer wraps to slot 0", wr_base, BASE);
      step(0, 1, 0, 0, 0);
      // reader drains across the wrap
      for (int k = 0; k < N; k++) begin
         step(0, 0, 1, 0, 0);
         step(0, 0, 0, 0, 1);
      end
      chk(rd_blocked == 1, "R4 drained ring blocks reader", rd_blocked, 1);

      // pseudo-random sweep with simultaneous events
      seed = 32'h1234_5678;
      for (int t = 0; t < 4000; t++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         step(seed[16], seed[18] & seed[19], seed[20], seed[21], seed[22] & seed[23]);
      end

      // R8: frame-sync gated instance
      do_reset();
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      chk(f_rd_blocked == 0, "R8 sync instance sees finished frame", f_rd_blocked, 0);
      step(0, 0, 1, 0, 0);
      chk(f_rd_grant == 0, "R8 request without sync held off", f_rd_grant, 0);
      chk(rd_grant == 1, "R8 sync ignored when disabled", rd_grant, 1);
      step(0, 0, 1, 1, 0);
      chk(f_rd_grant == 1, "R8 request on sync granted", f_rd_grant, 1);
      chk(f_rd_base == AW'(BASE), "R8 sync grant base", f_rd_base, BASE);
      chk(f_ready_cnt == 0, "R8/R7 sync instance count", f_ready_cnt, 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule